// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block sits behind a small host register window. It fetches one 16-bit word from a serial configuration EEPROM that uses a four-wire link (chip select, serial clock, data toward the EEPROM, data from the EEPROM). The host writes one command word to the control register. That single write carries a launch flag and an 8-bit word address. The block then runs the serial read frame on its own. It raises a busy flag while the frame is running. When the frame ends, the fetched word appears in the data register.

Software starts a read and polls the busy flag in the control register until it drops, then reads the data register. Word addresses count 16-bit words, so a table of several words is read with one command per word. A typical example is a six-byte station address held in three words from word 0x10 upward, with the low byte first in each word. The serial clock is the system clock divided down by a parameter. This keeps the EEPROM within its rated clock speed.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, the control and data registers read 0x0000, and chip select, serial clock and serial data out are low.
- R2: A host write to offset 0x36 with bit 9 set, made while the block is idle, starts a read of the word whose address is in bits 7:0. From the next cycle, bit 15 of the control register reads 1.
- R3: A frame raises chip select. It then shifts out a start bit 1, the read opcode bits 1 then 0, and the 8 address bits MSB first. Each bit is placed on serial data out while the serial clock is low and is held steady while the clock is high.
- R4: After the 11th rising edge of the serial clock, the block captures serial data in on each of the next 16 rising edges, MSB first. The assembled word reads at offset 0x34.
- R5: The data register keeps its old value while busy. It takes the new word in the same cycle that bit 15 of the control register returns to 0.
- R6: The serial clock high and low phases each last exactly HALF_DIV system clock cycles, measured from the rise of chip select.
- R7: A start command written while busy is ignored. The frame in flight keeps its address and result, and no extra frame follows.
- R8: A control write with bit 9 clear, and a write to any offset other than 0x36, start nothing and change no register.
- R9: Between two frames, chip select stays low for at least two half periods of the serial clock (2*HALF_DIV cycles).
- R10: The control register reads the busy flag in bit 15 and the address of the last accepted command in bits 7:0. Bits 14:8 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Host write strobe, one cycle per write |
| reg_addr | input | 8 | Host register byte offset, for both read and write |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for the offset on reg_addr, combinational |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Two events can land in the same cycle: a host start command, and the end of a frame, when the data register loads and busy drops. To provoke this, the bench holds a start command for a second address on the control port every cycle, while a first read finishes. It also polls the busy flag in each of those cycles. The command that coincides with the completing cycle must be dropped. The command in the first idle cycle must launch exactly one new frame. The judgement rests on three observations: the EEPROM model sees the first frame's address intact, exactly two frames appear, and the data register ends holding the second word.

// File: rtl/ee_rd_pkg.sv
// Package: shared constants and the state type of the EEPROM word reader.
// Assumes 8-bit register byte offsets and a 16-bit register data path.
package ee_rd_pkg;
    localparam logic [7:0] CTRL_OFS  = 8'h36;
    localparam logic [7:0] DATA_OFS  = 8'h34;
    localparam int         START_BIT = 9;
    localparam int         BUSY_BIT  = 15;
    localparam logic [1:0] RD_OPCODE = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } ee_state_t;
endpackage

// File: rtl/ee_tick_gen.sv
// Module: produces a one-cycle tick every HALF_DIV system cycles. Each tick
// marks the end of one serial clock half period. The clear input restarts
// the count so that the first half period after a start is a full one.
// Assumes HALF_DIV >= 1.
module ee_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_W'(HALF_DIV - 1));

    // Count system cycles within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ee_serial_engine.sv
// Module: runs one serial read frame. It sends the start bit, the opcode
// and the address, then captures DATA_W bits. After that it holds chip
// select low for two half periods before it returns to idle.
// Assumes that start is presented only while busy is low, and that tick
// comes from ee_tick_gen, cleared on the accepted start.
module ee_serial_engine
    import ee_rd_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GAP_W   = $clog2(GAP_MIN + 1);

    ee_state_t         state_q;
    logic [CMD_W-1:0]  out_sr_q;
    logic [DATA_W-1:0] in_sr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              gap_half_q;
    logic              cs_q;
    logic              sk_q;

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_GAP) && tick && gap_half_q;
    assign word  = in_sr_q;
    assign ee_cs = cs_q;
    assign ee_sk = sk_q;
    assign ee_di = cs_q & out_sr_q[CMD_W-1];

    // Frame sequencer: one serial clock phase per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            out_sr_q   <= '0;
            in_sr_q    <= '0;
            idx_q      <= '0;
            gap_half_q <= 1'b0;
            cs_q       <= 1'b0;
            sk_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_SHIFT;
                        cs_q     <= 1'b1;
                        sk_q     <= 1'b0;
                        out_sr_q <= {1'b1, RD_OPCODE, start_addr};
                        idx_q    <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                            if (idx_q >= IDX_W'(CMD_W))
                                in_sr_q <= {in_sr_q[DATA_W-2:0], ee_do};
                        end else begin
                            sk_q <= 1'b0;
                            if (idx_q == IDX_W'(FRAME_W - 1)) begin
                                state_q    <= ST_GAP;
                                cs_q       <= 1'b0;
                                gap_half_q <= 1'b0;
                            end else begin
                                idx_q    <= idx_q + 1'b1;
                                out_sr_q <= out_sr_q << 1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half_q) state_q <= ST_IDLE;
                        else            gap_half_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker counter: cycles that chip select has been low, saturating.
    logic [GAP_W-1:0] low_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           low_cnt_q <= GAP_W'(GAP_MIN);
        else if (cs_q)                        low_cnt_q <= '0;
        else if (low_cnt_q != GAP_W'(GAP_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
    end

    p_sk_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk)
        else $error("serial clock active without chip select");

    p_sk_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ee_sk))
        else $error("serial clock moved between ticks");

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |-> (low_cnt_q >= GAP_W'(GAP_MIN)))
        else $error("chip select gap too short");
endmodule

// File: rtl/eeprom_word_reader.sv
// Module: host register front end of the EEPROM word reader. The control
// register accepts a start command with a word address and reports busy.
// The data register holds the last word read. Register reads are
// combinational on reg_addr. Assumes one-cycle write strobes.
module eeprom_word_reader
    import ee_rd_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic              busy;
    logic              eng_done;
    logic              tick;
    logic              cmd_hit;
    logic              accept;
    logic [DATA_W-1:0] eng_word;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign cmd_hit = reg_wen && (reg_addr == CTRL_OFS) && reg_wdata[START_BIT];
    assign accept  = cmd_hit && !busy;

    ee_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .tick  (tick)
    );

    ee_serial_engine #(
        .HALF_DIV (HALF_DIV),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_addr (reg_wdata[ADDR_W-1:0]),
        .tick       (tick),
        .busy       (busy),
        .done       (eng_done),
        .word       (eng_word),
        .ee_cs      (ee_cs),
        .ee_sk      (ee_sk),
        .ee_di      (ee_di),
        .ee_do      (ee_do)
    );

    // Latch the word address of each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= reg_wdata[ADDR_W-1:0];
    end

    // Load the data register when a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (eng_done) data_q <= eng_word;
    end

    // Decode host register reads.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[ADDR_W-1:0] = addr_q;
            reg_rdata[BUSY_BIT]   = busy;
        end else if (reg_addr == DATA_OFS) begin
            reg_rdata = data_q;
        end
    end

    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy)
        else $error("accepted command did not raise busy");

    p_busy_drops_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy) |=> $stable(addr_q))
        else $error("command accepted while busy");

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(data_q))
        else $error("data register changed outside completion");

    p_done_clears_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy)
        else $error("busy still set after completion");
endmodule

// File: tb/test_eeprom_word_reader.sv
module test_eeprom_word_reader;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    eeprom_word_reader #(.HALF_DIV(H)) i_eeprom_word_reader (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    function automatic logic [15:0] model_word(input logic [7:0] a);
        return {~a, a ^ 8'hC3};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // EEPROM model and link monitor, sampled away from the active edge.
    int cyc = 0, last_evt = 0, cs_fall_cyc = 0;
    bit fall_seen = 1'b0;
    int m_cnt = 0;
    logic [10:0] m_cmd = '0;
    int frames = 0;
    logic [7:0] frame_addr = '0;
    int cmd_err = 0, di_err = 0;
    int sk_min = 1000, sk_max = 0, gap_min = 1000;
    logic cs_p = 1'b0, sk_p = 1'b0, di_p = 1'b0;

    always @(negedge clk) begin
        logic [15:0] w;
        cyc++;
        if (ee_cs && !cs_p) begin
            last_evt = cyc;
            m_cnt = 0;
            if (fall_seen && (cyc - cs_fall_cyc) < gap_min) gap_min = cyc - cs_fall_cyc;
        end
        if (!ee_cs && cs_p) begin
            cs_fall_cyc = cyc;
            fall_seen = 1'b1;
            ee_do = 1'b0;
        end
        if (ee_cs && cs_p && ee_sk != sk_p) begin
            if (cyc - last_evt < sk_min) sk_min = cyc - last_evt;
            if (cyc - last_evt > sk_max) sk_max = cyc - last_evt;
            last_evt = cyc;
            if (ee_sk) begin
                if (m_cnt < 11) m_cmd = {m_cmd[9:0], ee_di};
                m_cnt++;
                if (m_cnt == 11) begin
                    frames++;
                    frame_addr = m_cmd[7:0];
                    if (m_cmd[10:8] != 3'b110) cmd_err++;
                end
            end else if (m_cnt >= 11 && m_cnt < 27) begin
                w = model_word(m_cmd[7:0]);
                ee_do = w[26 - m_cnt];
            end
        end
        if (ee_cs && cs_p && ee_sk && sk_p && ee_di != di_p) di_err++;
        cs_p = ee_cs; sk_p = ee_sk; di_p = ee_di;
    end

    task automatic wr(input logic [7:0] ofs, input logic [15:0] val);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ofs; reg_wdata = val;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ofs, output logic [15:0] val);
        reg_addr = ofs;
        #1 val = reg_rdata;
    endtask

    // Poll until idle; meanwhile the data register must not move (R5).
    task automatic wait_idle(input logic [15:0] old_data, output int moved);
        logic [15:0] c, d;
        moved = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            #2;
            rd(8'h34, d);
            rd(8'h36, c);
            if (c[15] && d != old_data) moved++;
            if (!c[15]) break;
        end
    endtask

    localparam logic [15:0] VEC [8] = '{16'h0210, 16'h0211, 16'h0212, 16'h0200,
                                        16'h02FF, 16'h0280, 16'h0255, 16'h02AA};

    initial begin
        repeat (100000) @(posedge clk);
        if (!summary_done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, prev;
        int moved, f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h36, v); chk("R1 ctrl after reset", v, 0);
        rd(8'h34, v); chk("R1 data after reset", v, 0);
        chk("R1 link idle", {ee_cs, ee_sk, ee_di}, 0);

        // Table of reads: R2, R3, R4, R5, R10
        prev = 16'h0000;
        foreach (VEC[i]) begin
            f0 = frames;
            wr(8'h36, VEC[i]);
            rd(8'h36, v);
            chk("R2 busy after start", v[15], 1);
            chk("R10 ctrl address", v[14:0], {7'd0, VEC[i][7:0]});
            wait_idle(prev, moved);
            chk("R5 data held while busy", moved, 0);
            rd(8'h34, v);
            chk("R4 word read", v, model_word(VEC[i][7:0]));
            chk("R3 frame address", frame_addr, VEC[i][7:0]);
            chk("R3 one frame per command", frames - f0, 1);
            rd(8'h36, v);
            chk("R10 ctrl idle", v, {8'd0, VEC[i][7:0]});
            prev = model_word(VEC[i][7:0]);
        end

        // R8: ignored writes
        f0 = frames;
        wr(8'h36, 16'h0033);
        wr(8'h34, 16'h0277);
        repeat (3 * H) @(negedge clk);
        rd(8'h36, v); chk("R8 ctrl unchanged", v, 16'h00AA);
        rd(8'h34, v); chk("R8 data unchanged", v, model_word(8'hAA));
        chk("R8 no frame", frames - f0, 0);

        // R7: command while busy
        f0 = frames;
        wr(8'h36, 16'h0221);
        repeat (20) @(negedge clk);
        wr(8'h36, 16'h0242);
        rd(8'h36, v); chk("R7 address kept", v[7:0], 8'h21);
        wait_idle(model_word(8'hAA), moved);
        rd(8'h34, v); chk("R7 result of first read", v, model_word(8'h21));
        chk("R7 no extra frame", frames - f0, 1);
        chk("R7 frame address", frame_addr, 8'h21);

        // Same-cycle case: command held every cycle across completion (R5, R7, R9)
        f0 = frames;
        wr(8'h36, 16'h0213);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 8'h36; reg_wdata = 16'h0266;
        for (int k = 0; k < 2000; k++) begin
            #1;
            if (!reg_rdata[15]) break;
            @(negedge clk);
        end
        chk("R7 first frame intact", frame_addr, 8'h13);
        @(negedge clk);
        reg_wen = 1'b0;
        rd(8'h36, v); chk("R2 relaunch on first idle cycle", v, 16'h8066);
        wait_idle(model_word(8'h13), moved);
        rd(8'h34, v); chk("R5 word after back-to-back", v, model_word(8'h66));
        chk("R7 exactly two frames", frames - f0, 2);

        // Link-level checks
        chk("R3 start and opcode bits", cmd_err, 0);
        chk("R3 data out stable while clock high", di_err, 0);
        chk("R6 shortest half period", sk_min, H);
        chk("R6 longest half period", sk_max, H);
        chk("R9 chip select gap", (gap_min >= 2 * H) ? 1 : 0, 1);

        // R1: reset in the middle of a frame
        wr(8'h36, 16'h0201);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fall_seen = 1'b0;
        rd(8'h36, v); chk("R1 ctrl after mid-frame reset", v, 0);
        rd(8'h34, v); chk("R1 data after mid-frame reset", v, 0);
        chk("R1 link idle after mid-frame reset", {ee_cs, ee_sk, ee_di}, 0);

        summary_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule